// File: doc/BRIEF.md
# Packed Colour Palette Lookup

This block is the colour palette of a display controller. Software fills it over a simple register bus and reads it back. The pixel pipeline then uses it to turn an 8-bit pixel index into a 24-bit RGB colour. The storage is 128 words of 32 bits, and each word carries two 16-bit palette entries, which gives 256 colours in total.

The bus window begins at byte offset 0x200 and covers one 32-bit word every four bytes. A bus read returns the raw word exactly as it was written, including bits that the colour path ignores. On the pixel side, an index presented with a valid strobe gives the expanded colour one cycle later. Each 5-bit channel is widened to 8 bits, and a swap input can exchange the red and blue outputs for panels wired in blue-green-red order.

Top module: `pal_lookup`

## Requirements
- R1: After a synchronous active-low reset, `rgb_valid` and `bus_rvalid` are low, the RGB outputs are zero, and every stored word reads back as zero.
- R2: A bus write to a byte address from 0x200 to 0x3FF stores `bus_wdata` into word (address − 0x200) >> 2. Address bits 1:0 are ignored.
- R3: A bus read sets `bus_rvalid` high in the next cycle, with `bus_rdata` equal to the raw 32-bit word stored at the addressed index.
- R4: A bus write outside 0x200–0x3FF changes no stored word. A bus read outside that window returns zero, with `bus_rvalid` high in the next cycle.
- R5: Palette index 2k takes its entry from bits 15:0 of word k. Index 2k+1 takes its entry from bits 31:16 of word k.
- R6: In each 16-bit entry, red sits in bits 4:0, green in bits 9:5 and blue in bits 14:10. Each channel output is its 5-bit field shifted left by three, so output bits 2:0 are always zero.
- R7: Bit 15 of an entry has no effect on the colour output.
- R8: When `bgr_swap` is high in the cycle an index is presented, `rgb_red` carries the blue field and `rgb_blue` carries the red field. `rgb_green` is unchanged.
- R9: `rgb_valid` is high exactly one cycle after `pix_valid` is high. When `pix_valid` is low, the RGB outputs keep their previous values.
- R10: A lookup in the same cycle as a bus write to the word holding that entry returns the old entry. A lookup in the following cycle returns the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bgr_swap | input | 1 | Exchange red and blue on the colour output |
| pix_valid | input | 1 | Pixel index valid |
| pix_index | input | 8 | Palette index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_red | output | 8 | Red output channel |
| rgb_green | output | 8 | Green output channel |
| rgb_blue | output | 8 | Blue output channel |

## Verification
A corrupted stored word shows up in the colours of both entries it holds, and also on bus readback of that word, one cycle after the lookup or read that touches it. A wrong half select or wrong field mapping shows up as a channel landing on the wrong output. This happens on the first lookup of an entry whose halves or fields differ, which is why the test patterns give every field a distinct value. An error in bypass ordering shows up only when a write and a lookup of the same word fall in the same cycle, so that collision is driven explicitly.

// File: rtl/pal_pkg.sv
// Package: shared widths and the colour type used by the palette lookup.
// Assumes three equal-width channels packed low-to-high as red, green, blue.
package pal_pkg;
    localparam int CH_W     = 5;           // stored bits per channel
    localparam int OUT_W    = 8;           // output bits per channel
    localparam int NUM_CH   = 3;           // red, green, blue
    localparam int COLOR_W  = NUM_CH * CH_W;
    localparam int ENTRY_W  = 16;          // colour bits plus one unused flag bit

    typedef struct packed {
        logic [OUT_W-1:0] red;
        logic [OUT_W-1:0] green;
        logic [OUT_W-1:0] blue;
    } pal_rgb_t;
endpackage

// File: rtl/pal_bus_port.sv
// Module: pal_bus_port
// Decodes the palette's bus window, turns in-window writes into store write
// enables, and returns read data one cycle after a read strobe.
// Assumes the store read port is combinational; a miss reads as zero.
module pal_bus_port #(
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 128,
    parameter int BASE_ADDR = 'h200
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic                         st_wr_en,
    output logic [$clog2(NUM_WORDS)-1:0] st_idx,
    output logic [WORD_W-1:0]            st_wdata,
    input  logic [WORD_W-1:0]            st_rdata,
    output logic [WORD_W-1:0]            bus_rdata,
    output logic                         bus_rvalid
);
    localparam int WIDX_W  = $clog2(NUM_WORDS);
    localparam int BYTE_SH = $clog2(WORD_W / 8);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE_ADDR + NUM_WORDS * (WORD_W / 8));

    logic [ADDR_W:0] addr_ext;
    logic [ADDR_W:0] offset;
    logic            hit;

    // Window decode and word index from the byte offset.
    always_comb begin
        addr_ext = {1'b0, bus_addr};
        offset   = addr_ext - WIN_LO;
        hit      = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
        st_idx   = WIDX_W'(offset >> BYTE_SH);
        st_wr_en = bus_wr && hit;
        st_wdata = bus_wdata;
    end

    // Register read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= hit ? st_rdata : '0;
            end
        end
    end

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);                                   // R3
    AST_RVALID_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);                                 // R3
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == '0));                  // R4
endmodule

// File: rtl/pal_word_store.sv
// Module: pal_word_store
// Register array of raw palette words with one write port and two
// combinational read ports (bus readback and pixel lookup).
// Assumes a write becomes visible to readers from the next cycle.
module pal_word_store #(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0] wr_idx,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [$clog2(NUM_WORDS)-1:0] a_idx,
    output logic [WORD_W-1:0]            a_data,
    input  logic [$clog2(NUM_WORDS)-1:0] b_idx,
    output logic [WORD_W-1:0]            b_data
);
    logic [WORD_W-1:0] mem [NUM_WORDS];

    // Clear on reset, otherwise accept one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Both read ports see the array state before any same-cycle write.
    always_comb begin
        a_data = mem[a_idx];
        b_data = mem[b_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (a_idx == wr_idx)) |=> (a_data == $past(wr_data)) || (a_idx != $past(a_idx))); // R2
endmodule

// File: rtl/pal_entry_expand.sv
// Module: pal_entry_expand
// Widens the three colour fields of one entry to output width by appending
// zeros and optionally exchanges red and blue.
// Assumes the flag bit has already been stripped by the caller.
module pal_entry_expand
    import pal_pkg::*;
(
    input  logic [COLOR_W-1:0] color,
    input  logic               swap,
    output pal_rgb_t           rgb
);
    localparam int PAD_W = OUT_W - CH_W;

    logic [OUT_W-1:0] wide [NUM_CH];

    // One widening per channel: field in the top bits, zeros below.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wide[c] = {color[c*CH_W +: CH_W], {PAD_W{1'b0}}};
    end

    // Channel routing with the optional red/blue exchange.
    always_comb begin
        rgb.red   = swap ? wide[2] : wide[0];
        rgb.green = wide[1];
        rgb.blue  = swap ? wide[0] : wide[2];
    end
endmodule

// File: rtl/pal_lookup.sv
// Module: pal_lookup
// Palette top: bus-written store of packed two-entry words, and a one-cycle
// pixel lookup that selects the half-word entry and expands it to RGB.
// Assumes the index's low bit selects the half; lookups see pre-write data.
module pal_lookup
    import pal_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 128,
    parameter int BASE_ADDR = 'h200,
    parameter int IDX_W     = $clog2(NUM_WORDS * (WORD_W / ENTRY_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              bgr_swap,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_index,
    output logic              rgb_valid,
    output logic [OUT_W-1:0]  rgb_red,
    output logic [OUT_W-1:0]  rgb_green,
    output logic [OUT_W-1:0]  rgb_blue
);
    localparam int HALVES = WORD_W / ENTRY_W;
    localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int WIDX_W = $clog2(NUM_WORDS);

    logic              st_wr_en;
    logic [WIDX_W-1:0] st_idx;
    logic [WORD_W-1:0] st_wdata;
    logic [WORD_W-1:0] st_rdata;
    logic [WIDX_W-1:0] lk_idx;
    logic [WORD_W-1:0] lk_word;
    logic [ENTRY_W-1:0] halves [HALVES];
    logic [ENTRY_W-1:0] sel_entry;
    logic [COLOR_W-1:0] sel_color;
    pal_rgb_t           rgb_next;

    pal_bus_port #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .st_wr_en   (st_wr_en),
        .st_idx     (st_idx),
        .st_wdata   (st_wdata),
        .st_rdata   (st_rdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    pal_word_store #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (st_idx),
        .wr_data (st_wdata),
        .a_idx   (st_idx),
        .a_data  (st_rdata),
        .b_idx   (lk_idx),
        .b_data  (lk_word)
    );

    // Upper index bits pick the word.
    assign lk_idx = WIDX_W'(pix_index >> HALF_W);

    // Split the looked-up word into its packed entries.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign halves[h] = lk_word[h*ENTRY_W +: ENTRY_W];
    end

    // Low index bits pick the entry; the flag bit is dropped here.
    always_comb begin
        sel_entry = halves[pix_index[HALF_W-1:0]];
        sel_color = COLOR_W'(sel_entry);
    end

    pal_entry_expand u_expand (
        .color (sel_color),
        .swap  (bgr_swap),
        .rgb   (rgb_next)
    );

    // Output stage: capture on a valid index, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_valid <= 1'b0;
            rgb_red   <= '0;
            rgb_green <= '0;
            rgb_blue  <= '0;
        end else begin
            rgb_valid <= pix_valid;
            if (pix_valid) begin
                rgb_red   <= rgb_next.red;
                rgb_green <= rgb_next.green;
                rgb_blue  <= rgb_next.blue;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> rgb_valid);                                 // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !rgb_valid);                               // R9
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ($stable(rgb_red) && $stable(rgb_green) && $stable(rgb_blue))); // R9
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> ((rgb_red[OUT_W-CH_W-1:0] == '0) && (rgb_green[OUT_W-CH_W-1:0] == '0)
                       && (rgb_blue[OUT_W-CH_W-1:0] == '0)));     // R6
endmodule

// File: tb/pal_lookup_tb.sv
// Scoreboard bench: driver tasks push expected colours and read words into
// queues; a monitor pops and compares them as the outputs appear.
module pal_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        bgr_swap = 1'b0, pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        rgb_valid;
    logic [7:0]  rgb_red, rgb_green, rgb_blue;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [128];
    logic [23:0] exp_rgb_q [$];
    string       rgb_tag_q [$];
    logic [31:0] exp_rd_q [$];
    string       rd_tag_q [$];
    logic [23:0] last_rgb = '0;
    logic        mon_on = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pal_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bgr_swap(bgr_swap), .pix_valid(pix_valid),
        .pix_index(pix_index), .rgb_valid(rgb_valid), .rgb_red(rgb_red),
        .rgb_green(rgb_green), .rgb_blue(rgb_blue)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] colour(logic [7:0] idx, logic sw);
        logic [31:0] w = model[idx[7:1]];
        logic [15:0] e = idx[0] ? w[31:16] : w[15:0];
        logic [7:0] r = {e[4:0], 3'b000};
        logic [7:0] g = {e[9:5], 3'b000};
        logic [7:0] b = {e[14:10], 3'b000};
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    function automatic bit in_win(logic [11:0] a);
        return (a >= 12'h200) && (a < 12'h400);
    endfunction

    // Each task starts at a falling edge and ends at the next one.
    task automatic write_lookup(logic [11:0] a, logic [31:0] d, bit do_wr,
                                bit do_lk, logic [7:0] idx, logic sw, string tag);
        if (do_lk) begin
            exp_rgb_q.push_back(colour(idx, sw));
            rgb_tag_q.push_back(tag);
        end
        if (do_wr && in_win(a)) model[(a - 12'h200) >> 2] = d;
        bus_wr = do_wr; bus_addr = a; bus_wdata = d;
        pix_valid = do_lk; pix_index = idx; bgr_swap = sw;
        @(negedge clk);
        bus_wr = 1'b0; pix_valid = 1'b0;
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        write_lookup(a, d, 1'b1, 1'b0, 8'h00, 1'b0, "");
    endtask

    task automatic lookup(logic [7:0] idx, logic sw, string tag);
        write_lookup(12'h000, 32'h0, 1'b0, 1'b1, idx, sw, tag);
    endtask

    task automatic bus_read(logic [11:0] a, string tag);
        exp_rd_q.push_back(in_win(a) ? model[(a - 12'h200) >> 2] : 32'h0);
        rd_tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: compares outputs against the scoreboard on falling edges.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rgb_valid) begin
                if (exp_rgb_q.size() == 0) begin
                    check("R9 unexpected rgb_valid", 32'h1, 32'h0);
                end else begin
                    check(rgb_tag_q.pop_front(), {8'h0, rgb_red, rgb_green, rgb_blue},
                          {8'h0, exp_rgb_q.pop_front()});
                end
                last_rgb = {rgb_red, rgb_green, rgb_blue};
            end else begin
                check("R9 hold while idle", {8'h0, rgb_red, rgb_green, rgb_blue}, {8'h0, last_rgb});
            end
            if (bus_rvalid) begin
                if (exp_rd_q.size() == 0) begin
                    check("R3 unexpected bus_rvalid", 32'h1, 32'h0);
                end else begin
                    check(rd_tag_q.pop_front(), bus_rdata, exp_rd_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state seen at the ports.
        check("R1 rgb_valid", {31'h0, rgb_valid}, 32'h0);
        check("R1 bus_rvalid", {31'h0, bus_rvalid}, 32'h0);
        check("R1 rgb zero", {8'h0, rgb_red, rgb_green, rgb_blue}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        bus_read(12'h214, "R1 cleared word");
        bus_read(12'h3FC, "R1 cleared last word");

        // R5/R6: pure channels in each half.
        bus_write(12'h200, 32'h03E0_001F);
        bus_write(12'h204, 32'hFC00_7C00);
        lookup(8'd0, 1'b0, "R6 red field");
        lookup(8'd1, 1'b0, "R5 high half green");
        lookup(8'd2, 1'b0, "R6 blue field");
        // R7: entry 3 equals entry 2 except for the flag bit.
        lookup(8'd3, 1'b0, "R7 flag bit ignored");
        // R8: exchange of red and blue.
        lookup(8'd0, 1'b1, "R8 red to blue");
        lookup(8'd2, 1'b1, "R8 blue to red");
        lookup(8'd1, 1'b1, "R8 green unchanged");
        // R3: raw readback including bit 15 and bit 31.
        bus_read(12'h204, "R3 raw readback");

        // R2: low address bits ignored; last word of the window.
        bus_write(12'h20B, 32'h1234_5678);
        bus_read(12'h208, "R2 unaligned write");
        bus_write(12'h3FC, 32'h8421_7BDE);
        bus_read(12'h3FC, "R2 last word");
        lookup(8'd254, 1'b0, "R5 index 254");
        lookup(8'd255, 1'b0, "R5 index 255");

        // R4: outside the window on both sides.
        bus_write(12'h1FC, 32'hDEAD_BEEF);
        bus_write(12'h400, 32'hCAFE_F00D);
        bus_read(12'h200, "R4 low miss no effect");
        bus_read(12'h3FC, "R4 high miss no effect");
        bus_read(12'h400, "R4 miss reads zero");
        bus_read(12'h1FC, "R4 miss reads zero low");

        // R10: collision of write and lookup of the same word.
        write_lookup(12'h210, 32'h5555_2AAA, 1'b1, 1'b1, 8'd8, 1'b0, "R10 old value");
        write_lookup(12'h210, 32'h0000_7FFF, 1'b1, 1'b1, 8'd9, 1'b0, "R10 new value next cycle");
        lookup(8'd8, 1'b0, "R10 newest value");

        // R9: idle gap, then back-to-back lookups.
        repeat (3) @(negedge clk);

        // Full sweep with distinct fields in every entry.
        for (int k = 0; k < 128; k++) begin
            bus_write(12'h200 + 12'(k * 4), 32'(k) * 32'h9E37_79B1 ^ 32'h3C5A_A5C3);
        end
        for (int i = 0; i < 256; i++) begin
            lookup(8'(i), 1'(i % 3 == 0), "R5 R6 R8 sweep");
        end
        for (int k = 0; k < 128; k += 9) begin
            bus_read(12'h200 + 12'(k * 4), "R3 sweep readback");
        end

        repeat (4) @(negedge clk);
        check("R9 pending colours", exp_rgb_q.size(), 0);
        check("R3 pending reads", exp_rd_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule